// File: doc/BRIEF.md
# Power Management Timer and Status Event Block

This block holds three power management status flags: a timer carry flag, a bus master flag and a global flag. It sits on a small I/O bus with a 10-bit address, and it keeps a free-running power management counter. The counter advances on each cycle in which the tick-enable input is high. The timer carry flag is raised each time the counter's top bit changes, in either direction. The bus master flag and the global flag are raised through their companion bits in a control register. Software clears a flag by writing 1 to its position. Clearing the bus master or global flag also clears its companion control bit.

The block decodes a 16-byte window at a base address that the configuration logic supplies. The window is accepted only from 100h up to 3F0h. A single level output reports a power management event while the timer flag and its enable bit are both set. Within the window, the offsets are as follows:
- Offset 0: status register.
- Offset 2: enable register.
- Offset 4: control register.
- Offsets 8, 9 and 10: the counter, low byte first.

Top module: `pm_evt_blk`

## Requirements
- R1: After reset, every register and the counter are zero. Status bits 1–3 and 6–7 always read 0, and writing to them changes nothing.
- R2: Status bit 0 (timer carry) sets in the same cycle that the counter's most significant bit goes from 0 to 1 or from 1 to 0.
- R3: Writing 1 to a status bit position clears that bit. Writing 0 leaves it unchanged. If a set event and a clear write hit the same bit in the same cycle, the bit is 1 afterwards.
- R4: `pm_event` is 1 exactly while enable register bit 0 and status bit 0 are both 1.
- R5: Writing 1 to control bit 0 (bus master control) sets status bit 4. Writing 1 to status bit 4 clears both status bit 4 and control bit 0.
- R6: Writing 1 to control bit 2 (firmware release) sets status bit 5. Writing 1 to status bit 5 clears both status bit 5 and control bit 2.
- R7: The block responds only when `io_addr[9:4]` equals `base_addr[9:4]` and `base_addr[9:8]` is not zero. `base_addr[3:0]` is ignored.
- R8: A read of any address outside the decoded block, or of an unused offset inside it, returns 00h. A write there changes nothing.
- R9: The counter increments by one on each cycle in which `tick_en` is high and wraps to zero after its all-ones value. Offsets 8, 9 and 10 read bits 7:0, 15:8 and 23:16 of the counter, zero-extended to 24 bits.
- R10: The enable register holds only bit 0, and the control register holds only bits 0 and 2. All other bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 10 | Programmed block base address |
| io_addr | input | 10 | I/O address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational, zero unless a decoded read) |
| tick_en | input | 1 | Counter advance enable |
| pm_event | output | 1 | Level power management event |

## Verification
A wrong flag appears at the status read on the first read after the edge that should have changed it. It also reaches `pm_event` on that same edge once the enable bit is set, so a missed toggle of the counter's top bit is visible after a single tick. A broken link between a status flag and its companion control bit appears on the very next read of the control register. A decode fault appears in the sweep over all 64 aligned bases: either a write lands where it should not, or a read returns nonzero outside the window. The counter is checked byte by byte at its half-way point and at its wrap point, where a fault in carry or width would show first.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int TMR_W  = 24;

  // offsets inside the 16-byte window
  localparam logic [3:0] OFF_STS  = 4'h0;
  localparam logic [3:0] OFF_ENA  = 4'h2;
  localparam logic [3:0] OFF_CTL  = 4'h4;
  localparam logic [3:0] OFF_CNT0 = 4'h8;
  localparam logic [3:0] OFF_CNT1 = 4'h9;
  localparam logic [3:0] OFF_CNT2 = 4'hA;

  // status bit positions
  localparam int STS_TMR = 0;
  localparam int STS_BM  = 4;
  localparam int STS_GBL = 5;
  // enable / control bit positions
  localparam int ENA_TMR = 0;
  localparam int CTL_BM  = 0;
  localparam int CTL_FW  = 2;

  typedef struct packed {
    logic tmr;
    logic bm;
    logic gbl;
  } pm_flags_t;

  // a base is usable when it lies at or above 100h
  function automatic logic base_ok(input logic [ADDR_W-1:0] b);
    return b[ADDR_W-1:ADDR_W-2] != 2'b00;
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] a);
    return base_ok(b) && (a[ADDR_W-1:4] == b[ADDR_W-1:4]);
  endfunction

  // byte k of a 24-bit value
  function automatic logic [7:0] byte_sel(input logic [TMR_W-1:0] v,
                                          input int unsigned k);
    return v[8*k +: 8];
  endfunction

  // W1C with set priority
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/pm_addr_dec.sv
module pm_addr_dec
  import pm_evt_pkg::*;
(
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              hit,
  output logic [3:0]        offset,
  output logic              wr_sts,
  output logic              wr_ena,
  output logic              wr_ctl,
  output logic              rd_hit
);
  always_comb begin
    hit    = in_window(base_addr, io_addr);
    offset = io_addr[3:0];
    wr_sts = io_wr && hit && (offset == OFF_STS);
    wr_ena = io_wr && hit && (offset == OFF_ENA);
    wr_ctl = io_wr && hit && (offset == OFF_CTL);
    rd_hit = io_rd && hit;
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_evt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] cnt_ext,
  output logic             msb_toggle
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt    = tick_en ? cnt + 1'b1 : cnt;
    msb_toggle = cnt_nxt[MSB] ^ cnt[MSB];
    cnt_ext    = TMR_W'(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sts,
  input  logic              wr_ena,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              msb_toggle,
  output pm_flags_t         sts,
  output logic              tmr_en,
  output logic              bm_ctrl,
  output logic              fw_rls,
  output logic              clr_bm,
  output logic              clr_gbl
);
  logic set_bm, set_gbl, clr_tmr;
  pm_flags_t sts_n;
  logic bm_ctrl_n, fw_rls_n, tmr_en_n;

  always_comb begin
    set_bm  = wr_ctl && wdata[CTL_BM];
    set_gbl = wr_ctl && wdata[CTL_FW];
    clr_tmr = wr_sts && wdata[STS_TMR];
    clr_bm  = wr_sts && wdata[STS_BM];
    clr_gbl = wr_sts && wdata[STS_GBL];

    sts_n.tmr = flag_next(sts.tmr, msb_toggle, clr_tmr);
    sts_n.bm  = flag_next(sts.bm,  set_bm,     clr_bm);
    sts_n.gbl = flag_next(sts.gbl, set_gbl,    clr_gbl);

    tmr_en_n  = wr_ena ? wdata[ENA_TMR] : tmr_en;

    if (wr_ctl)      bm_ctrl_n = wdata[CTL_BM];
    else if (clr_bm) bm_ctrl_n = 1'b0;
    else             bm_ctrl_n = bm_ctrl;

    if (wr_ctl)       fw_rls_n = wdata[CTL_FW];
    else if (clr_gbl) fw_rls_n = 1'b0;
    else              fw_rls_n = fw_rls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      tmr_en  <= 1'b0;
      bm_ctrl <= 1'b0;
      fw_rls  <= 1'b0;
    end else begin
      sts     <= sts_n;
      tmr_en  <= tmr_en_n;
      bm_ctrl <= bm_ctrl_n;
      fw_rls  <= fw_rls_n;
    end
  end
endmodule

// File: rtl/pm_evt_blk.sv
module pm_evt_blk
  import pm_evt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  base_addr,
  input  logic [9:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        tick_en,
  output logic        pm_event
);
  logic             hit, rd_hit, wr_sts, wr_ena, wr_ctl;
  logic [3:0]       offset;
  logic [TMR_W-1:0] cnt_ext;
  logic             msb_toggle;
  pm_flags_t        sts;
  logic             tmr_en, bm_ctrl, fw_rls, clr_bm, clr_gbl;

  pm_addr_dec u_dec (
    .base_addr(base_addr), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .hit(hit), .offset(offset), .wr_sts(wr_sts), .wr_ena(wr_ena),
    .wr_ctl(wr_ctl), .rd_hit(rd_hit)
  );

  pm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_ext(cnt_ext), .msb_toggle(msb_toggle)
  );

  pm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wr_ena(wr_ena),
    .wr_ctl(wr_ctl), .wdata(io_wdata), .msb_toggle(msb_toggle),
    .sts(sts), .tmr_en(tmr_en), .bm_ctrl(bm_ctrl), .fw_rls(fw_rls),
    .clr_bm(clr_bm), .clr_gbl(clr_gbl)
  );

  logic [7:0] sts_byte, ena_byte, ctl_byte;

  always_comb begin
    sts_byte = '0;
    sts_byte[STS_TMR] = sts.tmr;
    sts_byte[STS_BM]  = sts.bm;
    sts_byte[STS_GBL] = sts.gbl;
    ena_byte = '0;
    ena_byte[ENA_TMR] = tmr_en;
    ctl_byte = '0;
    ctl_byte[CTL_BM]  = bm_ctrl;
    ctl_byte[CTL_FW]  = fw_rls;

    io_rdata = '0;
    if (rd_hit) begin
      unique case (offset)
        OFF_STS:  io_rdata = sts_byte;
        OFF_ENA:  io_rdata = ena_byte;
        OFF_CTL:  io_rdata = ctl_byte;
        OFF_CNT0: io_rdata = byte_sel(cnt_ext, 0);
        OFF_CNT1: io_rdata = byte_sel(cnt_ext, 1);
        OFF_CNT2: io_rdata = byte_sel(cnt_ext, 2);
        default:  io_rdata = '0;
      endcase
    end
    pm_event = tmr_en & sts.tmr;
  end
endmodule

// File: rtl/pm_evt_chk.sv
module pm_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic       hit,
  input logic [7:0] io_rdata,
  input logic       msb_toggle,
  input logic       sts_tmr,
  input logic       sts_bm,
  input logic       sts_gbl,
  input logic       tmr_en,
  input logic       bm_ctrl,
  input logic       fw_rls,
  input logic       pm_event,
  input logic       tick_en,
  input logic [7:0] cnt_lo
);
  a_r2_toggle_sets: assert property (@(posedge clk) disable iff (!rst_n)
    msb_toggle |=> sts_tmr);
  a_r3_tmr_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_tmr) |-> $past(msb_toggle));
  a_r4_event_level: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && sts_tmr) |-> pm_event);
  a_r4_event_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_tmr |-> !pm_event);
  a_r5_bm_link: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_bm) |-> !bm_ctrl);
  a_r5_bm_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_ctrl) |-> sts_bm);
  a_r6_gbl_link: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_gbl) |-> !fw_rls);
  a_r6_gbl_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fw_rls) |-> sts_gbl);
  a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || !hit) |-> (io_rdata == 8'h00));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_lo == $past(cnt_lo) + 8'd1);
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_lo));
endmodule

bind pm_evt_blk pm_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .hit(hit), .io_rdata(io_rdata),
  .msb_toggle(msb_toggle), .sts_tmr(sts.tmr), .sts_bm(sts.bm),
  .sts_gbl(sts.gbl), .tmr_en(tmr_en), .bm_ctrl(bm_ctrl), .fw_rls(fw_rls),
  .pm_event(pm_event), .tick_en(tick_en), .cnt_lo(cnt_ext[7:0])
);

// File: tb/tb_pm_evt_blk.sv
module tb_pm_evt_blk;
  localparam int CLK_P = 10;
  localparam int CW    = 12;
  localparam int HALF  = 1 << (CW - 1);
  localparam logic [9:0] BASE = 10'h250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] base_addr = BASE;
  logic [9:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0, tick_en = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       pm_event;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int unsigned exp_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  pm_evt_blk #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tick_en(tick_en), .pm_event(pm_event)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [9:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    exp_cnt = (exp_cnt + n) % (1 << CW);
  endtask

  task automatic chk_cnt(input string req);
    rchk(req, BASE + 10'h8, exp_cnt & 8'hFF);
    rchk(req, BASE + 10'h9, (exp_cnt >> 8) & 8'hFF);
    rchk(req, BASE + 10'hA, (exp_cnt >> 16) & 8'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rchk("R1 sts", BASE, 0);
    rchk("R1 ena", BASE + 2, 0);
    rchk("R1 ctl", BASE + 4, 0);
    chk_cnt("R1 cnt");
    chk("R1 event", pm_event, 0);
    wr(BASE, 8'hCE);
    rchk("R1 reserved", BASE, 0);

    // R10 register widths
    wr(BASE + 2, 8'hFF);
    rchk("R10 ena", BASE + 2, 8'h01);
    wr(BASE + 2, 8'h00);
    rchk("R10 ena clr", BASE + 2, 0);
    wr(BASE + 4, 8'hFA);
    rchk("R10 ctl", BASE + 4, 8'h00);

    // R7 / R8 sweep of all aligned bases, junk in low base bits
    for (int b = 0; b < 64; b++) begin
      logic [9:0] ba;
      ba = 10'(b << 4);
      base_addr = ba | 10'(b & 15);
      wr(ba + 2, 8'h01);
      rchk("R7 decode", ba + 2, (b >= 16) ? 1 : 0);
      rchk("R8 outside", (ba ^ 10'h010) + 2, 0);
      rchk("R8 unused", ba + 6, 0);
      wr(ba + 2, 8'h00);
    end
    base_addr = BASE;
    wr(BASE + 7, 8'hFF);
    rchk("R8 unused wr", BASE + 2, 0);

    // R2/R4/R9 rising MSB
    wr(BASE + 2, 8'h01);
    tick(HALF - 1);
    rchk("R2 pre", BASE, 0);
    chk("R4 idle", pm_event, 0);
    chk_cnt("R9 half-1");
    tick(1);
    rchk("R2 rise", BASE, 8'h01);
    chk("R4 event", pm_event, 1);
    chk_cnt("R9 half");
    // R3 write zero no effect, then clear
    wr(BASE, 8'h00);
    rchk("R3 w0", BASE, 8'h01);
    wr(BASE, 8'h01);
    rchk("R3 w1c", BASE, 0);
    chk("R4 drop", pm_event, 0);
    // falling MSB / wrap
    tick(HALF - 1);
    rchk("R2 pre fall", BASE, 0);
    tick(1);
    rchk("R2 fall", BASE, 8'h01);
    chk_cnt("R9 wrap");
    wr(BASE + 2, 8'h00);
    chk("R4 disabled", pm_event, 0);
    wr(BASE, 8'h01);

    // R3 set wins over same-cycle clear
    tick(HALF - 1);
    rchk("R3 pre", BASE, 0);
    @(negedge clk);
    tick_en = 1'b1; io_addr = BASE; io_wdata = 8'h01; io_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; io_wr = 1'b0;
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    rchk("R3 set wins", BASE, 8'h01);
    chk_cnt("R9 after race");
    wr(BASE, 8'h01);

    // R5 bus master link
    wr(BASE + 4, 8'h01);
    rchk("R5 sts", BASE, 8'h10);
    rchk("R5 ctl", BASE + 4, 8'h01);
    wr(BASE, 8'h00);
    rchk("R5 w0", BASE, 8'h10);
    wr(BASE, 8'h10);
    rchk("R5 clr sts", BASE, 0);
    rchk("R5 clr ctl", BASE + 4, 0);

    // R6 firmware release link
    wr(BASE + 4, 8'h04);
    rchk("R6 sts", BASE, 8'h20);
    rchk("R6 ctl", BASE + 4, 8'h04);
    wr(BASE + 4, 8'h00);
    rchk("R6 sticky", BASE, 8'h20);
    wr(BASE + 4, 8'h05);
    rchk("R6 both", BASE, 8'h30);
    wr(BASE, 8'h20);
    rchk("R6 clr sts", BASE, 8'h10);
    rchk("R6 clr ctl", BASE + 4, 8'h01);
    wr(BASE, 8'h10);
    rchk("R5 final", BASE + 4, 0);

    finish_run();
  end
endmodule